// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block caches virtual-to-physical page translations in a small table that is searched all at once. Each lookup presents a virtual page number, the identifier of the running address space, and the kind of access (plain read, write, or instruction fetch). The block answers in the same cycle with exactly one of three outcomes. A hit returns the physical frame and the permission bits. A fault means the translation exists but forbids this access. A miss means an outside walker must fetch the translation from the page tables.

The walker installs its result through the fill port. A fill may pin its entry so that later replacement never evicts it. Because every entry carries its address-space identifier, a context switch needs no flush. Software can still discard translations, either all of them or those of one identifier. Pinned entries survive both kinds of discard.

Replacement first uses the lowest-numbered empty entry. Once the table is full, a round-robin pointer picks the victim and steps over pinned entries. A fill whose page number and identifier are already present rewrites that entry in place.

Top module: `tlb_assoc`

## Requirements
- R1: With `lk_req` high, an entry that is valid and matches both `lk_vpn` and `lk_asid` drives `lk_hit` (or `lk_fault`), `lk_pfn` and `lk_prot` combinationally in the same cycle. With no matching entry, `lk_miss` is high and `lk_pfn`/`lk_prot` read zero.
- R2: An entry matches only when its stored identifier equals `lk_asid`. The same page number under a different identifier misses.
- R3: An accepted fill is written at the clock edge. A lookup in the fill's own cycle still sees the old contents, and a lookup of that page from the next cycle onward hits.
- R4: A fill of a page not yet present goes to the lowest-numbered invalid entry when one exists, and the round-robin pointer does not move.
- R5: When every entry is valid, the victim is the first non-pinned entry at or after the round-robin pointer, wrapping around. The pointer then moves to the entry after the victim.
- R6: A pinned entry (fill with `fill_wired` high) is never chosen as a victim.
- R7: Permission bit 0 allows writes and bit 1 allows instruction fetch; reads need only a valid entry. A matching access that is not allowed raises `lk_fault` with `lk_hit` and `lk_miss` low.
- R8: `flush_all` invalidates every non-pinned entry at the clock edge. Pinned entries keep translating.
- R9: `flush_asid_en` invalidates only the non-pinned entries whose identifier equals `flush_asid`.
- R10: A fill whose page and identifier are already present overwrites that entry, including its pinned flag, and never creates a second matching entry.
- R11: A fill presented in the same cycle as either flush is discarded.
- R12: A fill of a new page when every entry is valid and pinned is discarded and the table is unchanged.
- R13: With `lk_req` low, `lk_hit`, `lk_miss` and `lk_fault` are all low.
- R14: After reset every entry is invalid, nothing is pinned and the round-robin pointer is at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_wr | input | 1 | Access is a write |
| lk_ex | input | 1 | Access is an instruction fetch |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry forbids the access |
| lk_pfn | output | PFN_W | Physical frame number of the matching entry |
| lk_prot | output | 2 | Permission bits of the matching entry |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Identifier to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_prot | input | 2 | Permission bits to install |
| fill_wired | input | 1 | Pin the installed entry |
| flush_all | input | 1 | Invalidate all non-pinned entries |
| flush_asid_en | input | 1 | Invalidate non-pinned entries of one identifier |
| flush_asid | input | ASID_W | Identifier for the selective flush |

## Verification
Lookup results are combinational, so they are due in the same cycle as the request. The bench drives each request on the falling edge and samples one time unit later, well before the next rising edge. Fills and flushes take effect at the following rising edge, so the bench updates its reference table only after that edge. The request in the fill's own cycle is compared against the old contents. Replacement order is never read from inside the design. It shows up through later hits and misses, which the bench predicts from its own victim rule.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_DEF = 8;
  localparam int PROT_W   = 2;
  localparam int PROT_WR  = 0;   // write permitted
  localparam int PROT_EX  = 1;   // instruction fetch permitted

  typedef logic [PROT_W-1:0] prot_t;

  // True when the stored permissions forbid the requested access.
  function automatic logic prot_denies(input prot_t p, input logic wr, input logic ex);
    return (wr && !p[PROT_WR]) || (ex && !p[PROT_EX]);
  endfunction
endpackage

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  // Lowest set bit wins.
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [VPN_W-1:0]  vpn_tab  [ENTRIES],
  input  logic [ASID_W-1:0] asid_tab [ENTRIES],
  input  logic [ENTRIES-1:0] valid,
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic [ENTRIES-1:0] match_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = valid[i] && (vpn_tab[i] == key_vpn) && (asid_tab[i] == key_asid);
  end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int ENTRIES = 32,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] wired,
  input  logic [IW-1:0]      rr,
  output logic [IW-1:0]      slot,
  output logic               ok,
  output logic               by_rr
);
  logic [ENTRIES-1:0] free_v, cand_v, at_or_after, cand_hi;
  logic [IW-1:0] free_idx, hi_idx, lo_idx;
  logic free_any, hi_any, lo_any;

  assign free_v = ~valid;
  assign cand_v = ~wired;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_mask
    assign at_or_after[i] = (IW'(i) >= rr);
  end
  assign cand_hi = cand_v & at_or_after;

  tlb_first_set #(.W(ENTRIES)) u_free (.vec(free_v),  .idx(free_idx), .found(free_any));
  tlb_first_set #(.W(ENTRIES)) u_hi   (.vec(cand_hi), .idx(hi_idx),   .found(hi_any));
  tlb_first_set #(.W(ENTRIES)) u_lo   (.vec(cand_v),  .idx(lo_idx),   .found(lo_any));

  always_comb begin
    slot  = '0;
    ok    = 1'b1;
    by_rr = 1'b0;
    if (free_any) begin
      slot = free_idx;
    end else if (hi_any) begin
      slot  = hi_idx;
      by_rr = 1'b1;
    end else if (lo_any) begin
      slot  = lo_idx;
      by_rr = 1'b1;
    end else begin
      ok = 1'b0;
    end
  end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int ASID_W  = ASID_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_req,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [ASID_W-1:0]   lk_asid,
  input  logic                lk_wr,
  input  logic                lk_ex,
  output logic                lk_hit,
  output logic                lk_miss,
  output logic                lk_fault,
  output logic [PFN_W-1:0]    lk_pfn,
  output logic [PROT_W-1:0]   lk_prot,
  input  logic                fill_en,
  input  logic [VPN_W-1:0]    fill_vpn,
  input  logic [ASID_W-1:0]   fill_asid,
  input  logic [PFN_W-1:0]    fill_pfn,
  input  logic [PROT_W-1:0]   fill_prot,
  input  logic                fill_wired,
  input  logic                flush_all,
  input  logic                flush_asid_en,
  input  logic [ASID_W-1:0]   flush_asid
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]   tab_vpn  [ENTRIES];
  logic [ASID_W-1:0]  tab_asid [ENTRIES];
  logic [PFN_W-1:0]   tab_pfn  [ENTRIES];
  prot_t              tab_prot [ENTRIES];
  logic [ENTRIES-1:0] valid, wired;
  logic [IDX_W-1:0]   rr;

  function automatic logic [IDX_W-1:0] step_ptr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  // ---------------- lookup path ----------------
  logic [ENTRIES-1:0] lk_match;
  logic [IDX_W-1:0]   lk_idx;
  logic               lk_any, lk_deny;

  tlb_tag_cmp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cmp (
    .vpn_tab(tab_vpn), .asid_tab(tab_asid), .valid(valid),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .match_vec(lk_match));
  tlb_first_set #(.W(ENTRIES)) u_lk_enc (.vec(lk_match), .idx(lk_idx), .found(lk_any));

  assign lk_deny  = prot_denies(tab_prot[lk_idx], lk_wr, lk_ex);
  assign lk_hit   = lk_req && lk_any && !lk_deny;
  assign lk_fault = lk_req && lk_any && lk_deny;
  assign lk_miss  = lk_req && !lk_any;
  assign lk_pfn   = (lk_req && lk_any) ? tab_pfn[lk_idx]  : '0;
  assign lk_prot  = (lk_req && lk_any) ? tab_prot[lk_idx] : '0;

  // ---------------- fill path ----------------
  logic [ENTRIES-1:0] fl_match;
  logic [IDX_W-1:0]   fl_idx, vic_slot, fill_slot;
  logic               fl_any, vic_ok, vic_by_rr, flush_any, fill_go, rr_step;

  tlb_tag_cmp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_cmp (
    .vpn_tab(tab_vpn), .asid_tab(tab_asid), .valid(valid),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .match_vec(fl_match));
  tlb_first_set #(.W(ENTRIES)) u_fl_enc (.vec(fl_match), .idx(fl_idx), .found(fl_any));
  tlb_victim_pick #(.ENTRIES(ENTRIES)) u_vic (
    .valid(valid), .wired(wired), .rr(rr),
    .slot(vic_slot), .ok(vic_ok), .by_rr(vic_by_rr));

  assign flush_any = flush_all || flush_asid_en;
  assign fill_go   = fill_en && !flush_any && (fl_any || vic_ok);
  assign fill_slot = fl_any ? fl_idx : vic_slot;
  assign rr_step   = fill_go && !fl_any && vic_by_rr;

  // ---------------- flush path ----------------
  logic [ENTRIES-1:0] kill;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_kill
    assign kill[i] = !wired[i] && (flush_all || (flush_asid_en && tab_asid[i] == flush_asid));
  end

  // ---------------- state ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      wired <= '0;
      rr    <= '0;
    end else begin
      valid <= valid & ~kill;
      if (fill_go) begin
        valid[fill_slot] <= 1'b1;
        wired[fill_slot] <= fill_wired;
      end
      if (rr_step) rr <= step_ptr(vic_slot);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tab_vpn[fill_slot]  <= fill_vpn;
      tab_asid[fill_slot] <= fill_asid;
      tab_pfn[fill_slot]  <= fill_pfn;
      tab_prot[fill_slot] <= fill_prot;
    end
  end

  // ---------------- assertions ----------------
  // R7
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_fault}));
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> !(lk_hit || lk_miss || lk_fault));
  // R10
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  // R6
  victim_unpinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_ok |-> !wired[vic_slot]);
  // R8
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> ((valid & ~wired) == '0) && $stable(wired));
  // R3
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> valid[$past(fill_slot)]);
  // R12
  full_pinned_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fl_any && (&wired)) |=> $stable(valid));
endmodule

// File: tb/tlb_assoc_tb.sv
module tlb_assoc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int VW = 12;
  localparam int PW = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_req, lk_wr, lk_ex, fill_en, fill_wired, flush_all, flush_asid_en;
  logic [VW-1:0] lk_vpn, fill_vpn;
  logic [AW-1:0] lk_asid, fill_asid, flush_asid;
  logic [PW-1:0] fill_pfn, lk_pfn;
  logic [1:0]    fill_prot, lk_prot;
  logic lk_hit, lk_miss, lk_fault;

  int total = 0;
  int bad = 0;
  logic last_hit, last_miss, last_fault;
  logic [PW-1:0] last_pfn;

  // reference table
  bit            m_valid [N];
  bit            m_wired [N];
  logic [VW-1:0] m_vpn   [N];
  logic [AW-1:0] m_asid  [N];
  logic [PW-1:0] m_pfn   [N];
  logic [1:0]    m_prot  [N];
  int            m_rr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_assoc #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_wr(lk_wr), .lk_ex(lk_ex),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_pfn(lk_pfn), .lk_prot(lk_prot),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
    .fill_prot(fill_prot), .fill_wired(fill_wired),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid));

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0;
      m_wired[i] = 0;
    end
    m_rr = 0;
  endtask

  // permission rule: bit0 write, bit1 fetch
  function automatic bit forbids(input logic [1:0] p, input logic w, input logic x);
    return (w && p[0] == 1'b0) || (x && p[1] == 1'b0);
  endfunction

  task automatic cmp_lookup(input string tag);
    int k;
    logic e_hit, e_miss, e_fault;
    logic [PW-1:0] e_pfn;
    logic [1:0] e_prot;
    k = -1;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == lk_vpn && m_asid[i] == lk_asid) k = i;
    e_miss  = lk_req && (k < 0);
    e_hit   = lk_req && (k >= 0) && !forbids(m_prot[k < 0 ? 0 : k], lk_wr, lk_ex);
    e_fault = lk_req && (k >= 0) && forbids(m_prot[k < 0 ? 0 : k], lk_wr, lk_ex);
    e_pfn   = (lk_req && k >= 0) ? m_pfn[k] : '0;
    e_prot  = (lk_req && k >= 0) ? m_prot[k] : '0;
    check({tag, " hit"},   32'(lk_hit),   32'(e_hit));
    check({tag, " miss"},  32'(lk_miss),  32'(e_miss));
    check({tag, " fault"}, 32'(lk_fault), 32'(e_fault));
    check({tag, " pfn"},   32'(lk_pfn),   32'(e_pfn));
    check({tag, " prot"},  32'(lk_prot),  32'(e_prot));
    last_hit = lk_hit; last_miss = lk_miss; last_fault = lk_fault; last_pfn = lk_pfn;
  endtask

  task automatic model_update();
    int slot;
    bit by_rr;
    if (flush_all || flush_asid_en) begin
      for (int i = 0; i < N; i++)
        if (!m_wired[i] && (flush_all || m_asid[i] == flush_asid)) m_valid[i] = 0;
      return;
    end
    if (!fill_en) return;
    slot = -1; by_rr = 0;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == fill_vpn && m_asid[i] == fill_asid) slot = i;
    if (slot < 0)
      for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
    if (slot < 0)
      for (int k = 0; k < N; k++)
        if (slot < 0 && !m_wired[(m_rr + k) % N]) begin
          slot = (m_rr + k) % N;
          by_rr = 1;
        end
    if (slot < 0) return;
    m_valid[slot] = 1; m_wired[slot] = fill_wired;
    m_vpn[slot] = fill_vpn; m_asid[slot] = fill_asid;
    m_pfn[slot] = fill_pfn; m_prot[slot] = fill_prot;
    if (by_rr) m_rr = (slot + 1) % N;
  endtask

  task automatic idle();
    lk_req = 0; lk_vpn = '0; lk_asid = '0; lk_wr = 0; lk_ex = 0;
    fill_en = 0; fill_vpn = '0; fill_asid = '0; fill_pfn = '0; fill_prot = '0; fill_wired = 0;
    flush_all = 0; flush_asid_en = 0; flush_asid = '0;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_cycle(input string tag);
    #1 cmp_lookup(tag);
    @(posedge clk);
    #1 model_update();
    @(negedge clk);
  endtask

  task automatic fill_op(input int vpn, input int asid, input int pfn,
                         input logic [1:0] prot, input logic wr_pin, input string tag);
    idle();
    fill_en = 1; fill_vpn = VW'(vpn); fill_asid = AW'(asid);
    fill_pfn = PW'(pfn); fill_prot = prot; fill_wired = wr_pin;
    do_cycle(tag);
  endtask

  task automatic probe(input int vpn, input int asid, input logic w, input logic x,
                       input logic exp_hit, input string tag);
    idle();
    lk_req = 1; lk_vpn = VW'(vpn); lk_asid = AW'(asid); lk_wr = w; lk_ex = x;
    do_cycle(tag);
    check({tag, " direct"}, 32'(last_hit), 32'(exp_hit));
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    model_clear();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();

    // R14: everything misses after reset
    probe(12'h010, 1, 0, 0, 0, "R14");
    check("R14 miss", 32'(last_miss), 32'd1);
    // R13: no request, no outcome
    idle(); lk_vpn = 12'h010; do_cycle("R13");
    check("R13 quiet", 32'({last_hit, last_miss, last_fault}), 32'd0);

    // R3: fill, same-cycle lookup sees old contents
    idle();
    fill_en = 1; fill_vpn = 12'h010; fill_asid = 8'd1; fill_pfn = 10'h055; fill_prot = 2'b11;
    lk_req = 1; lk_vpn = 12'h010; lk_asid = 8'd1;
    do_cycle("R3 same-cycle");
    check("R3 same-cycle miss", 32'(last_miss), 32'd1);
    probe(12'h010, 1, 0, 0, 1, "R3");
    // R1: frame returned
    check("R1 pfn", 32'(last_pfn), 32'h055);
    // R2: other identifier misses
    probe(12'h010, 2, 0, 0, 0, "R2");

    // R7: read-only, no-fetch entry
    fill_op(12'h020, 1, 10'h0aa, 2'b00, 0, "R7 fill");
    probe(12'h020, 1, 0, 0, 1, "R7 read");
    probe(12'h020, 1, 1, 0, 0, "R7 write");
    check("R7 write fault", 32'(last_fault), 32'd1);
    probe(12'h020, 1, 0, 1, 0, "R7 fetch");
    check("R7 fetch fault", 32'(last_fault), 32'd1);
    fill_op(12'h021, 1, 10'h0ab, 2'b01, 0, "R7 fill2");
    probe(12'h021, 1, 1, 0, 1, "R7 write ok");

    // R10: overwrite in place
    fill_op(12'h010, 1, 10'h066, 2'b11, 0, "R10 fill");
    probe(12'h010, 1, 0, 0, 1, "R10");
    check("R10 new pfn", 32'(last_pfn), 32'h066);

    // R11: fill together with flush is dropped
    idle(); fill_en = 1; fill_vpn = 12'h030; fill_asid = 8'd1; fill_pfn = 10'h1; fill_prot = 2'b11;
    flush_all = 1; do_cycle("R11 fill+flush");
    probe(12'h030, 1, 0, 0, 0, "R11");
    probe(12'h010, 1, 0, 0, 0, "R8 cleared");

    // R5/R6: full table, pinned entry skipped by round robin
    for (int i = 0; i < N; i++) fill_op(12'h100 + i, 3, 10'h100 + i, 2'b11, i == 0, "R5 fill");
    fill_op(12'h200, 3, 10'h200, 2'b11, 0, "R5 evict1");
    probe(12'h100, 3, 0, 0, 1, "R6 pinned kept");
    probe(12'h101, 3, 0, 0, 0, "R5 first victim");
    probe(12'h200, 3, 0, 0, 1, "R5 new entry");
    fill_op(12'h201, 3, 10'h201, 2'b11, 0, "R5 evict2");
    probe(12'h102, 3, 0, 0, 0, "R5 second victim");
    probe(12'h103, 3, 0, 0, 1, "R5 survivor");

    // R9: flush one identifier
    fill_op(12'h103, 3, 10'h103, 2'b11, 0, "R9 keep");
    idle(); flush_asid_en = 1; flush_asid = 8'd3; do_cycle("R9 flush");
    probe(12'h103, 3, 0, 0, 0, "R9 flushed");
    probe(12'h100, 3, 0, 0, 1, "R9 pinned kept");
    probe(12'h020, 1, 0, 0, 0, "R9 other id");  // cleared earlier by R8

    fill_op(12'h040, 7, 10'h040, 2'b11, 0, "R9 fill7");
    idle(); flush_asid_en = 1; flush_asid = 8'd6; do_cycle("R9 flush6");
    probe(12'h040, 7, 0, 0, 1, "R9 id7 kept");

    // R4: lowest-free placement, rr not moved (rr nonzero here)
    idle(); flush_all = 1; do_cycle("R4 flush");
    for (int i = 1; i < N; i++) fill_op(12'h300 + i, 4, 10'h300 + i, 2'b11, 0, "R4 fill");
    fill_op(12'h3ff, 4, 10'h3ff, 2'b11, 0, "R4 evict");
    for (int i = 1; i < N; i++) probe(12'h300 + i, 4, 0, 0, (i != 3), "R4");
    probe(12'h3ff, 4, 0, 0, 1, "R4 new");

    // R12: every entry pinned, new fill dropped
    do_reset();
    for (int i = 0; i < N; i++) fill_op(12'h400 + i, 5, 10'h0 + i, 2'b11, 1, "R12 fill");
    fill_op(12'h4ff, 5, 10'h3, 2'b11, 0, "R12 drop");
    probe(12'h4ff, 5, 0, 0, 0, "R12 absent");
    for (int i = 0; i < N; i++) probe(12'h400 + i, 5, 0, 0, 1, "R12 kept");

    // R1: constrained random against the reference table
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      idle();
      lk_req = ($urandom % 8) != 0;
      lk_vpn = VW'($urandom % 16); lk_asid = AW'($urandom % 4);
      lk_wr = ($urandom % 3) == 0; lk_ex = ($urandom % 4) == 0;
      fill_en = ($urandom % 3) == 0;
      fill_vpn = VW'($urandom % 16); fill_asid = AW'($urandom % 4);
      fill_pfn = PW'($urandom); fill_prot = 2'($urandom);
      fill_wired = ($urandom % 24) == 0;
      flush_all = ($urandom % 97) == 0;
      flush_asid_en = ($urandom % 41) == 0; flush_asid = AW'($urandom % 4);
      do_cycle("R1 random");
    end

    report();
    $finish;
  end
endmodule